// File: doc/BRIEF.md
# Zero-Address Stack Processor Core

This core runs a small program held in an external synchronous memory. Its arithmetic instructions name no operands. Each one takes its two inputs from an internal hardware operand stack and returns the single result to that stack. Only two instructions carry a memory address. One loads a memory word onto the stack. The other removes the top word and stores it to memory. Program words and data words share one memory port. That port has a single-cycle read latency.

Each instruction goes through fetch, decode and execute. The core keeps an eight-entry register stack with a depth counter. It refuses any operation that would take a word from an empty stack or place a word on a full one. In that case it raises a sticky error flag, halts, and leaves the stack and memory as they were. The top-of-stack word is brought out for observation. A dedicated stop instruction ends a program cleanly.

Top module: `stk_core`

## Requirements
- R1: While reset is asserted and right after it is released, the program counter is zero (so memAddr is 0), the stack is empty (tosOut reads 0), errFlag and halted are 0, and memWe is 0.
- R2: Instructions execute in ascending address order starting at address 0. A load-to-stack instruction takes four clock cycles and every other instruction takes three. This includes the stop instruction, which ends with halted high.
- R3: An instruction word is 16 bits: opcode in bits 15:12 and address in bits 11:0. Opcode 0x1 reads the word at the address and pushes it, and that word becomes tosOut.
- R4: Opcode 0x2 removes the top word and writes it to the address with one cycle of memWe. The word below it becomes tosOut.
- R5: Opcode 0x3 (add) and opcode 0x5 (multiply, low 16 bits kept) remove the top two words and push the result modulo 2^16. The stack depth drops by one.
- R6: Opcode 0x4 (subtract) produces the top word minus the word beneath it.
- R7: A load-to-stack instruction on a full stack (8 entries) sets errFlag and halts. The stack is left unchanged.
- R8: A store from an empty stack, or arithmetic with fewer than two entries, sets errFlag and halts. The stack and memory are left unchanged.
- R9: Opcode 0xF stops execution. After that, halted stays high, memAddr stays constant and memWe stays low until reset.
- R10: Opcodes 0x0 and 0x6 through 0xE do nothing except advance to the next instruction. Their address field is ignored.
- R11: The program: load E, load C, load D, multiply, load B, add, subtract, load F, add, load A, add, store A. It leaves B + C*D - E + F + A in the memory word of A.
- R12: errFlag stays set, and the core stays halted, until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| memAddr | output | 12 | Memory address for fetch, load and store |
| memWdata | output | 16 | Word written to memory by a store |
| memWe | output | 1 | Memory write strobe |
| memRdata | input | 16 | Word read from memory, valid one cycle after its address |
| halted | output | 1 | Core has stopped (stop opcode or error) |
| errFlag | output | 1 | Sticky stack underflow/overflow flag |
| tosOut | output | 16 | Current top-of-stack word, 0 when empty |

## Verification
Within one execute cycle, the core evaluates the depth check and the stack update together. An operation that would underflow or overflow must take the error path in the cycle where it would otherwise have moved the stack pointer or written memory. The bench provokes this with random programs. Their mixes of loads, stores and arithmetic often drive the stack past either edge. It also uses directed cases: a ninth load, a store from an empty stack, and a subtract with one entry. A bench stack model decides when execution stops. The bench then judges the final error flag, the top-of-stack word and every output memory cell, to show the faulting step left no trace.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OPC_NOP  = 4'h0;
  localparam logic [OP_W-1:0] OPC_PUSH = 4'h1;
  localparam logic [OP_W-1:0] OPC_POP  = 4'h2;
  localparam logic [OP_W-1:0] OPC_ADD  = 4'h3;
  localparam logic [OP_W-1:0] OPC_SUB  = 4'h4;
  localparam logic [OP_W-1:0] OPC_MUL  = 4'h5;
  localparam logic [OP_W-1:0] OPC_HALT = 4'hF;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_MUL = 2'd2
  } aluOp_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic   doPush;
    logic   doPop;
    logic   doArith;
    aluOp_e aluOp;
  } dpCtl_t;

  typedef enum logic [2:0] {
    S_FETCH,
    S_DECODE,
    S_EXEC,
    S_LOAD,
    S_HALT
  } state_e;
endpackage

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] opTop,
  input  logic [DATA_W-1:0] opNext,
  input  aluOp_e            aluOp,
  output logic [DATA_W-1:0] aluRes
);
  localparam int PROD_W = 2 * DATA_W;

  logic [PROD_W-1:0] product;

  always_comb begin
    product = PROD_W'(opTop) * PROD_W'(opNext);
    case (aluOp)
      ALU_ADD: aluRes = opTop + opNext;
      ALU_SUB: aluRes = opTop - opNext;   // top is the minuend
      ALU_MUL: aluRes = product[DATA_W-1:0];
      default: aluRes = '0;
    endcase
  end
endmodule

// File: rtl/stk_datapath.sv
module stk_datapath
  import stk_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] topVal,
  output logic              stEmpty,
  output logic              stFull,
  output logic              stHasTwo
);
  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] stk [DEPTH];
  logic [SP_W-1:0]   sp;
  logic [IDX_W-1:0]  topIdx;
  logic [IDX_W-1:0]  nextIdx;
  logic [DATA_W-1:0] nextVal;
  logic [DATA_W-1:0] aluRes;

  assign stEmpty  = (sp == '0);
  assign stFull   = (sp == SP_W'(DEPTH));
  assign stHasTwo = (sp >= SP_W'(2));

  assign topIdx  = IDX_W'(sp - SP_W'(1));
  assign nextIdx = IDX_W'(sp - SP_W'(2));
  assign topVal  = stEmpty  ? '0 : stk[topIdx];
  assign nextVal = stHasTwo ? stk[nextIdx] : '0;

  stk_alu #(.DATA_W(DATA_W)) u_alu (
    .opTop (topVal),
    .opNext(nextVal),
    .aluOp (ctl.aluOp),
    .aluRes(aluRes)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ctl.doPush && int'(sp) == i)
          stk[i] <= pushData;
        else if (ctl.doArith && int'(sp) == i + 2)
          stk[i] <= aluRes;
      end
      if (ctl.doPush)
        sp <= sp + SP_W'(1);
      else if (ctl.doPop || ctl.doArith)
        sp <= sp - SP_W'(1);
    end
  end

  // the sequencer must never ask for a push on a full stack
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    ctl.doPush |-> !stFull);
  p_no_underflow_pop_r8: assert property (@(posedge clk) disable iff (rst)
    ctl.doPop |-> !stEmpty);
  p_no_underflow_arith_r8: assert property (@(posedge clk) disable iff (rst)
    ctl.doArith |-> stHasTwo);
  p_push_value_r3: assert property (@(posedge clk) disable iff (rst)
    ctl.doPush |=> (topVal == $past(pushData)) && (sp == $past(sp) + SP_W'(1)));
  p_pop_shrinks_r4: assert property (@(posedge clk) disable iff (rst)
    ctl.doPop |=> sp == $past(sp) - SP_W'(1));
  p_arith_shrinks_r5: assert property (@(posedge clk) disable iff (rst)
    ctl.doArith |=> sp == $past(sp) - SP_W'(1));
  p_sub_order_r6: assert property (@(posedge clk) disable iff (rst)
    (ctl.doArith && ctl.aluOp == ALU_SUB) |=> topVal == $past(topVal) - $past(nextVal));
  p_idle_stable_r10: assert property (@(posedge clk) disable iff (rst)
    !(ctl.doPush || ctl.doPop || ctl.doArith) |=> $stable(sp));
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              stEmpty,
  input  logic              stFull,
  input  logic              stHasTwo,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output dpCtl_t            ctl,
  output logic              halted,
  output logic              errFlag
);
  localparam int INSTR_W = OP_W + ADDR_W;

  state_e             state, stNext;
  logic [ADDR_W-1:0]  pc;
  logic [INSTR_W-1:0] ir;
  logic [OP_W-1:0]    opcode;
  logic [ADDR_W-1:0]  opAddr;
  logic               errSet;

  assign opcode = ir[INSTR_W-1 -: OP_W];
  assign opAddr = ir[ADDR_W-1:0];
  assign halted = (state == S_HALT);

  always_comb begin
    stNext  = state;
    memAddr = pc;
    memWe   = 1'b0;
    errSet  = 1'b0;
    ctl     = '0;
    case (state)
      S_FETCH:  stNext = S_DECODE;
      S_DECODE: stNext = S_EXEC;
      S_EXEC: begin
        case (opcode)
          OPC_PUSH: begin
            if (stFull) begin
              errSet = 1'b1;
              stNext = S_HALT;
            end else begin
              memAddr = opAddr;
              stNext  = S_LOAD;
            end
          end
          OPC_POP: begin
            if (stEmpty) begin
              errSet = 1'b1;
              stNext = S_HALT;
            end else begin
              memAddr   = opAddr;
              memWe     = 1'b1;
              ctl.doPop = 1'b1;
              stNext    = S_FETCH;
            end
          end
          OPC_ADD, OPC_SUB, OPC_MUL: begin
            if (!stHasTwo) begin
              errSet = 1'b1;
              stNext = S_HALT;
            end else begin
              ctl.doArith = 1'b1;
              ctl.aluOp   = (opcode == OPC_ADD) ? ALU_ADD :
                            (opcode == OPC_SUB) ? ALU_SUB : ALU_MUL;
              stNext      = S_FETCH;
            end
          end
          OPC_HALT: stNext = S_HALT;
          default:  stNext = S_FETCH;
        endcase
      end
      S_LOAD: begin
        ctl.doPush = 1'b1;
        stNext     = S_FETCH;
      end
      S_HALT:  stNext = S_HALT;
      default: stNext = S_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_FETCH;
      pc      <= '0;
      ir      <= '0;
      errFlag <= 1'b0;
    end else begin
      state <= stNext;
      if (state == S_DECODE) begin
        ir <= memRdata[INSTR_W-1:0];
        pc <= pc + ADDR_W'(1);
      end
      if (errSet) errFlag <= 1'b1;
    end
  end

  p_err_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    errFlag |=> errFlag);
  p_err_halts_r8: assert property (@(posedge clk) disable iff (rst)
    errFlag |-> halted);
  p_halt_hold_r9: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && !memWe && $stable(memAddr));
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.doPush, ctl.doPop, ctl.doArith}));
  p_write_only_store_r4: assert property (@(posedge clk) disable iff (rst)
    memWe |-> ctl.doPop);
endmodule

// File: rtl/stk_core.sv
module stk_core
  import stk_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  input  logic [DATA_W-1:0] memRdata,
  output logic              halted,
  output logic              errFlag,
  output logic [DATA_W-1:0] tosOut
);
  dpCtl_t ctl;
  logic   stEmpty, stFull, stHasTwo;

  stk_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .memRdata(memRdata),
    .stEmpty (stEmpty),
    .stFull  (stFull),
    .stHasTwo(stHasTwo),
    .memAddr (memAddr),
    .memWe   (memWe),
    .ctl     (ctl),
    .halted  (halted),
    .errFlag (errFlag)
  );

  stk_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .pushData(memRdata),
    .topVal  (tosOut),
    .stEmpty (stEmpty),
    .stFull  (stFull),
    .stHasTwo(stHasTwo)
  );

  assign memWdata = tosOut;
endmodule

// File: tb/sim_stk_core.sv
`timescale 1ns/1ps
module sim_stk_core;
  localparam logic [3:0] PUSH = 4'h1, POP = 4'h2, ADD = 4'h3, SUB = 4'h4,
                         MUL = 4'h5, HALT = 4'hF, NOP = 4'h0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] memAddr;
  logic [15:0] memWdata, memRdata, tosOut;
  logic        memWe, halted, errFlag;
  logic [15:0] mem [256];
  int          nChecks = 0, nErrors = 0;

  always #2 clk = ~clk;

  stk_core u0 (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memWdata(memWdata),
    .memWe(memWe), .memRdata(memRdata), .halted(halted),
    .errFlag(errFlag), .tosOut(tosOut)
  );

  always @(posedge clk) begin
    if (memWe) mem[memAddr[7:0]] <= memWdata;
    memRdata <= mem[memAddr[7:0]];
  end

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
    return {op, a};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = '0;
  endtask

  // reset, release, then run until halted; returns edges counted
  task automatic runProg(output int cyc);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    cyc = 0;
    while (!halted && cyc < 600) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErrors++; nChecks++;
    $display("FAIL R2: watchdog expired actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    int cyc;
    logic [15:0] a, b, c, d, e, f;
    void'($urandom(32'd2024));
    clearMem();

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 memAddr", memAddr, 0);
    chk("R1 tosOut", tosOut, 0);
    chk("R1 errFlag", errFlag, 0);
    chk("R1 halted", halted, 0);
    chk("R1 memWe", memWe, 0);

    // R11 expression program, R2 cycle count
    a = 16'd2; b = 16'd3; c = 16'd5; d = 16'd7; e = 16'd4; f = 16'd10;
    mem[8'h80] = a; mem[8'h81] = b; mem[8'h82] = c;
    mem[8'h83] = d; mem[8'h84] = e; mem[8'h85] = f;
    mem[0]  = ins(PUSH, 12'h084); mem[1]  = ins(PUSH, 12'h082);
    mem[2]  = ins(PUSH, 12'h083); mem[3]  = ins(MUL, 12'h000);
    mem[4]  = ins(PUSH, 12'h081); mem[5]  = ins(ADD, 12'h000);
    mem[6]  = ins(SUB, 12'h000);  mem[7]  = ins(PUSH, 12'h085);
    mem[8]  = ins(ADD, 12'h000);  mem[9]  = ins(PUSH, 12'h080);
    mem[10] = ins(ADD, 12'h000);  mem[11] = ins(POP, 12'h080);
    mem[12] = ins(HALT, 12'h000);
    runProg(cyc);
    chk("R11 result in A", mem[8'h80], 16'd46);
    chk("R2 cycles to halt", cyc, 45);
    chk("R9 halted", halted, 1);
    chk("R11 no error", errFlag, 0);
    chk("R4 stack empty after store", tosOut, 0);

    // R3 R9: stop instruction blocks later store
    clearMem();
    mem[8'h80] = 16'hA5C3;
    mem[0] = ins(PUSH, 12'h080); mem[1] = ins(HALT, 12'h000); mem[2] = ins(POP, 12'h090);
    runProg(cyc);
    chk("R3 pushed word on top", tosOut, 16'hA5C3);
    chk("R2 push+halt cycles", cyc, 7);
    chk("R9 no store after halt", mem[8'h90], 0);
    a = {4'h0, memAddr};
    repeat (10) @(negedge clk);
    chk("R9 address frozen", {4'h0, memAddr}, a);
    chk("R9 still halted", halted, 1);
    chk("R9 no error from halt", errFlag, 0);

    // R10: no-op opcodes ignored
    clearMem();
    mem[8'h80] = 16'h1234;
    mem[0] = ins(PUSH, 12'h080); mem[1] = ins(NOP, 12'h090);
    mem[2] = ins(4'h9, 12'h091); mem[3] = ins(4'hE, 12'h092);
    mem[4] = ins(POP, 12'h093);  mem[5] = ins(HALT, 12'h000);
    runProg(cyc);
    chk("R10 word preserved", mem[8'h93], 16'h1234);
    chk("R10 untouched cell", mem[8'h90], 0);
    chk("R10 no error", errFlag, 0);

    // R7: overflow on ninth load
    clearMem();
    for (int k = 0; k < 9; k++) begin
      mem[8'h80 + k] = 16'h0100 + 16'(k);
      mem[k] = ins(PUSH, 12'h080 + 12'(k));
    end
    mem[9] = ins(HALT, 12'h000);
    runProg(cyc);
    chk("R7 errFlag", errFlag, 1);
    chk("R7 halted", halted, 1);
    chk("R7 top unchanged", tosOut, 16'h0107);
    repeat (20) @(negedge clk);
    chk("R12 error sticky", errFlag, 1);
    chk("R12 halt sticky", halted, 1);

    // R8: store from empty stack
    clearMem();
    mem[8'h90] = 16'hBEEF;
    mem[0] = ins(POP, 12'h090); mem[1] = ins(HALT, 12'h000);
    runProg(cyc);
    chk("R1 reset clears error", cyc > 0 ? 32'd1 : 32'd0, 1);
    chk("R8 pop-empty error", errFlag, 1);
    chk("R8 memory unchanged", mem[8'h90], 16'hBEEF);
    chk("R8 stack empty", tosOut, 0);

    // R8: subtract with one entry
    clearMem();
    mem[8'h80] = 16'h0042;
    mem[0] = ins(PUSH, 12'h080); mem[1] = ins(SUB, 12'h000); mem[2] = ins(HALT, 12'h000);
    runProg(cyc);
    chk("R8 arith-underflow error", errFlag, 1);
    chk("R8 top kept", tosOut, 16'h0042);

    // R5 R6: directed arithmetic with wrap
    clearMem();
    mem[8'h80] = 16'h0003; mem[8'h81] = 16'h0001;
    mem[8'h82] = 16'hFFFF; mem[8'h83] = 16'h0002;
    mem[0] = ins(PUSH, 12'h080); mem[1] = ins(PUSH, 12'h081); mem[2] = ins(SUB, 0);
    mem[3] = ins(POP, 12'h090);
    mem[4] = ins(PUSH, 12'h082); mem[5] = ins(PUSH, 12'h083); mem[6] = ins(ADD, 0);
    mem[7] = ins(POP, 12'h091);
    mem[8] = ins(PUSH, 12'h082); mem[9] = ins(PUSH, 12'h082); mem[10] = ins(MUL, 0);
    mem[11] = ins(POP, 12'h092); mem[12] = ins(HALT, 0);
    runProg(cyc);
    chk("R6 top minus next wraps", mem[8'h90], 16'hFFFE);
    chk("R5 add wraps", mem[8'h91], 16'h0001);
    chk("R5 mul low half", mem[8'h92], 16'h0001);

    // random programs against a bench stack model (R3..R8)
    for (int it = 0; it < 20; it++) begin
      logic [15:0] dat [16];
      logic [15:0] expOut [16];
      logic [15:0] st [8];
      int sp;
      bit err;
      sp = 0; err = 0;
      clearMem();
      for (int k = 0; k < 16; k++) begin
        dat[k] = 16'($urandom);
        mem[8'h80 + k] = dat[k];
        expOut[k] = '0;
      end
      for (int p = 0; p < 16; p++) begin
        int r, ai;
        logic [3:0] op;
        logic [11:0] ad;
        logic [15:0] t, n, res;
        r = $urandom_range(0, 99);
        ai = $urandom_range(0, 15);
        op = (r < 40) ? PUSH : (r < 55) ? POP : (r < 67) ? ADD :
             (r < 79) ? SUB : (r < 91) ? MUL : NOP;
        ad = (op == PUSH) ? 12'h080 + 12'(ai) :
             (op == POP)  ? 12'h090 + 12'(ai) : 12'($urandom);
        mem[p] = ins(op, ad);
        if (!err) begin
          case (op)
            PUSH: if (sp == 8) err = 1; else begin st[sp] = dat[ai]; sp++; end
            POP:  if (sp == 0) err = 1; else begin sp--; expOut[ai] = st[sp]; end
            ADD, SUB, MUL: begin
              if (sp < 2) err = 1;
              else begin
                t = st[sp-1]; n = st[sp-2];
                res = (op == ADD) ? t + n : (op == SUB) ? t - n : t * n;
                sp--; st[sp-1] = res;
              end
            end
            default: ;
          endcase
        end
      end
      mem[16] = ins(HALT, 0);
      runProg(cyc);
      chk("R8 random error flag", errFlag, err);
      chk("R5 random top", tosOut, (sp > 0) ? st[sp-1] : 16'h0);
      for (int k = 0; k < 16; k++)
        chk("R4 random stored word", mem[8'h90 + k], expOut[k]);
    end

    $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule